// File: doc/BRIEF.md
# Multiplexed Bar-Graph Charge Display Driver

This block turns a compensated remaining-capacity count and a full-scale reference into a five-segment relative bar graph. Each segment stands for one fifth of the reference. The segments are lit in two alternating banks through one shared common switch. The odd-numbered segments (1, 3 and 5) form bank A, and the even-numbered segments (2 and 4) form bank B. Each bank is given a fixed share of a repeating multiplex frame.

A two-bit display mode selects how the bar graph is shown. It can be off, shown only while a charge is active, or shown for a fixed time after the mode input is pulled low. Two warnings override the bar graph. The near-empty warning makes segment 1 blink. The final-empty warning turns every segment off. All timing is counted in a clock-enable tick, so the frame rate (about 100 Hz), the 30% bank share, the 4 Hz blink and the 4 s show time are all set by parameters.

Top module: `bargraph_led_drv`

## Requirements
- R1: The number of lit segments n is the count of k in 1..5 for which cap×5 ≥ k×full_ref. Segment i (bit i-1 of seg_en) may light only when n ≥ i, so cap = 0 lights none and cap ≥ full_ref lights all five.
- R2: Bank A is seg_en bits 0, 2 and 4. Bank B is bits 1 and 3. A segment of bank A and a segment of bank B are never on in the same cycle.
- R3: The frame is FRAME_TICKS ticks long. Bank A's window is the first ON_TICKS ticks of the frame. Bank B's window is ON_TICKS ticks starting at FRAME_TICKS/2. When the display is on, com_en is high exactly during these windows, and a segment is on only while com_en is high.
- R4: While warn_low is 1, segment 1 (bit 0) is shown only during the visible half of a blink cycle. The visible and dark halves each last BLINK_HALF ticks. The other segments are not affected.
- R5: While warn_empty is 1, seg_en is 0.
- R6: disp_mode 2'b10 and 2'b11 keep the display off and cancel any timed show. disp_mode 2'b01 shows the display while chg_active is 1.
- R7: When disp_mode changes to 2'b00 from any other value, the display turns on for SHOW_TICKS ticks. A new change to 2'b00 during a show restarts the full time.
- R8: While the display is off, com_en is 0 and seg_en is 0. This includes the reset state.
- R9: When full_ref is 0, no segment lights, whatever the value of cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase clock enable |
| cap | input | CAP_W | Compensated remaining capacity |
| full_ref | input | CAP_W | Full-scale reference |
| chg_active | input | 1 | Charge in progress |
| warn_low | input | 1 | First end-of-discharge warning |
| warn_empty | input | 1 | Final end-of-discharge warning |
| disp_mode | input | 2 | 00 timed show, 01 show on charge, 1x off |
| seg_en | output | 5 | Segment enables, bit 0 = segment 1 |
| com_en | output | 1 | Common switch enable |

## Verification
The level rule is tried with capacity values just below and exactly at each 20% threshold. The table also covers a capacity above the reference, a zero reference, a tiny reference where the rounding matters, and full-scale counts. Together these tell a correct ≥ compare from an off-by-one compare or a wrong scale. Each pattern is observed over whole multiplex frames. Those scans show the bank separation and the 6-of-10 common duty. Each warning is applied on top of a full bar. For the blink this tells a gated segment 1 from one that is always lit. The mode tests hold the timed show past its end and re-enter it partway through. This tells a restarting timer from a single-shot one.

// File: rtl/bargraph_pkg.sv
package bargraph_pkg;
  typedef enum logic [1:0] {
    DM_SHOW  = 2'b00,
    DM_CHG   = 2'b01,
    DM_OFF   = 2'b10,
    DM_OFF_X = 2'b11
  } disp_mode_e;

  localparam int NUM_SEG = 5;
  localparam logic [NUM_SEG-1:0] BANK_A_MASK = 5'b10101;
  localparam logic [NUM_SEG-1:0] BANK_B_MASK = 5'b01010;
endpackage

// File: rtl/bargraph_level.sv
module bargraph_level #(
  parameter int CAP_W = 16
) (
  input  logic [CAP_W-1:0] cap,
  input  logic [CAP_W-1:0] full_ref,
  output logic [2:0]       lit_cnt,
  output logic [4:0]       lit_mask
);
  localparam int EW = CAP_W + 3;

  function automatic logic [2:0] level_of(input logic [CAP_W-1:0] c,
                                          input logic [CAP_W-1:0] r);
    logic [EW-1:0] c5;
    logic [EW-1:0] thr;
    logic [2:0]    n;
    n  = 3'd0;
    c5 = EW'(c) * EW'(5);
    if (r != '0) begin
      for (int k = 1; k <= 5; k++) begin
        thr = EW'(r) * EW'(k);
        if (c5 >= thr) n = n + 3'd1;
      end
    end
    return n;
  endfunction

  always_comb begin
    lit_cnt = level_of(cap, full_ref);
    for (int i = 0; i < 5; i++) lit_mask[i] = (lit_cnt > 3'(i));
  end
endmodule

// File: rtl/bargraph_mux_timer.sv
module bargraph_mux_timer #(
  parameter int FRAME_TICKS = 10,
  parameter int ON_TICKS    = 3,
  parameter int BLINK_HALF  = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic win_a,
  output logic win_b,
  output logic blink_on
);
  localparam int HALF = FRAME_TICKS / 2;
  localparam int PW   = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1;
  localparam int BW   = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;

  logic [PW-1:0] phase;
  logic [BW-1:0] blink_cnt;
  logic          blink_wrap;

  assign blink_wrap = (blink_cnt == BW'(BLINK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      blink_cnt <= '0;
      blink_on  <= 1'b1;
    end else if (tick) begin
      phase     <= (phase == PW'(FRAME_TICKS - 1)) ? '0 : phase + 1'b1;
      blink_cnt <= blink_wrap ? '0 : blink_cnt + 1'b1;
      if (blink_wrap) blink_on <= ~blink_on;
    end
  end

  assign win_a = (phase < PW'(ON_TICKS));
  assign win_b = (phase >= PW'(HALF)) && (phase < PW'(HALF + ON_TICKS));

  AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && blink_wrap) |=> $stable(blink_on)); // R4
  AST_BLINK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blink_wrap) |=> (blink_on != $past(blink_on))); // R4
endmodule

// File: rtl/bargraph_disp_ctl.sv
module bargraph_disp_ctl
  import bargraph_pkg::*;
#(
  parameter int SHOW_TICKS = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] disp_mode,
  input  logic       chg_active,
  output logic       disp_on,
  output logic       show_start
);
  localparam int TW = $clog2(SHOW_TICKS + 1);

  logic [1:0]    prev_mode;
  logic [TW-1:0] show_left;
  logic          forced_off;

  assign forced_off = disp_mode[1];
  assign show_start = (disp_mode == DM_SHOW) && (prev_mode != DM_SHOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mode <= DM_SHOW;
      show_left <= '0;
    end else begin
      prev_mode <= disp_mode;
      if (forced_off)                    show_left <= '0;
      else if (show_start)               show_left <= TW'(SHOW_TICKS);
      else if (tick && show_left != '0)  show_left <= show_left - 1'b1;
    end
  end

  assign disp_on = !forced_off &&
                   ((show_left != '0) || (disp_mode == DM_CHG && chg_active));

  AST_SHOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    show_start |=> (show_left == TW'(SHOW_TICKS))); // R7
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    forced_off |=> (show_left == '0)); // R6
endmodule

// File: rtl/bargraph_led_drv.sv
module bargraph_led_drv
  import bargraph_pkg::*;
#(
  parameter int CAP_W       = 16,
  parameter int FRAME_TICKS = 10,
  parameter int ON_TICKS    = 3,
  parameter int BLINK_HALF  = 125,
  parameter int SHOW_TICKS  = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CAP_W-1:0] cap,
  input  logic [CAP_W-1:0] full_ref,
  input  logic             chg_active,
  input  logic             warn_low,
  input  logic             warn_empty,
  input  logic [1:0]       disp_mode,
  output logic [4:0]       seg_en,
  output logic             com_en
);
  logic [2:0] lit_cnt;
  logic [4:0] lit_mask;
  logic       win_a, win_b, blink_on;
  logic       disp_on, show_start;

  bargraph_level #(.CAP_W(CAP_W)) u_level (
    .cap(cap), .full_ref(full_ref), .lit_cnt(lit_cnt), .lit_mask(lit_mask)
  );

  bargraph_mux_timer #(
    .FRAME_TICKS(FRAME_TICKS), .ON_TICKS(ON_TICKS), .BLINK_HALF(BLINK_HALF)
  ) u_mux (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .win_a(win_a), .win_b(win_b), .blink_on(blink_on)
  );

  bargraph_disp_ctl #(.SHOW_TICKS(SHOW_TICKS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .disp_mode(disp_mode),
    .chg_active(chg_active), .disp_on(disp_on), .show_start(show_start)
  );

  assign com_en = disp_on && (win_a || win_b);

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    logic bank_win;
    logic gate;
    if (BANK_A_MASK[i]) begin : g_a
      assign bank_win = win_a;
    end else begin : g_b
      assign bank_win = win_b;
    end
    if (i == 0) begin : g_blink
      assign gate = !warn_low || blink_on;
    end else begin : g_plain
      assign gate = 1'b1;
    end
    assign seg_en[i] = disp_on && bank_win && lit_mask[i] && gate && !warn_empty;
  end

  AST_BANK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(seg_en & BANK_A_MASK) && |(seg_en & BANK_B_MASK))); // R2
  AST_SEG_NEEDS_COM: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_en != '0) |-> com_en); // R3
  AST_EMPTY_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    warn_empty |-> (seg_en == '0)); // R5
  AST_COM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (!com_en && seg_en == '0)); // R8
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lit_cnt <= 3'd5) && ($countones(seg_en) <= 3)); // R1
  AST_ZERO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (full_ref == '0) |-> (seg_en == '0)); // R9
endmodule

// File: tb/bargraph_led_drv_test.sv
module bargraph_led_drv_test;
  localparam int FR = 10, ON = 3, BH = 8, SH = 40;

  logic clk = 0, rst_n = 0, tick = 1;
  logic [15:0] cap = 0, full_ref = 0;
  logic chg_active = 0, warn_low = 0, warn_empty = 0;
  logic [1:0] disp_mode = 2'b10;
  logic [4:0] seg_en;
  logic com_en;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bargraph_led_drv #(.CAP_W(16), .FRAME_TICKS(FR), .ON_TICKS(ON),
    .BLINK_HALF(BH), .SHOW_TICKS(SH)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cap(cap), .full_ref(full_ref),
    .chg_active(chg_active), .warn_low(warn_low), .warn_empty(warn_empty),
    .disp_mode(disp_mode), .seg_en(seg_en), .com_en(com_en));

  // {cap, full_ref, expected lit count}
  localparam logic [34:0] VEC [14] = '{
    {16'd0,     16'd1000,  3'd0}, {16'd199,   16'd1000,  3'd0},
    {16'd200,   16'd1000,  3'd1}, {16'd399,   16'd1000,  3'd1},
    {16'd400,   16'd1000,  3'd2}, {16'd600,   16'd1000,  3'd3},
    {16'd799,   16'd1000,  3'd3}, {16'd800,   16'd1000,  3'd4},
    {16'd999,   16'd1000,  3'd4}, {16'd1000,  16'd1000,  3'd5},
    {16'd1500,  16'd1000,  3'd5}, {16'd100,   16'd0,     3'd0},
    {16'd3,     16'd7,     3'd2}, {16'd65535, 16'd65535, 3'd5}};

  logic [4:0] or_mask;
  int com_cnt, mix_cnt, s0_cnt, s1_cnt, s2_no_s0, s2_with_s0, any_seg;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic scan(input int n);
    or_mask = 0; com_cnt = 0; mix_cnt = 0; s0_cnt = 0; s1_cnt = 0;
    s2_no_s0 = 0; s2_with_s0 = 0; any_seg = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      or_mask |= seg_en;
      if (com_en) com_cnt++;
      if (|(seg_en & 5'b10101) && |(seg_en & 5'b01010)) mix_cnt++;
      if (seg_en[0]) s0_cnt++;
      if (seg_en[1]) s1_cnt++;
      if (seg_en[2] && !seg_en[0]) s2_no_s0++;
      if (seg_en[2] && seg_en[0]) s2_with_s0++;
      if (seg_en != 0 && !com_en) any_seg++;
    end
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(com_en == 0 && seg_en == 0, "R8 reset", {seg_en, com_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chg_active = 1; disp_mode = 2'b01;
    for (int v = 0; v < 14; v++) begin
      cap = VEC[v][34:19]; full_ref = VEC[v][18:3];
      scan(FR);
      chk(or_mask == 5'((1 << VEC[v][2:0]) - 1),
          VEC[v][18:3] == 0 ? "R9 zero ref" : "R1 level",
          or_mask, (1 << VEC[v][2:0]) - 1);
      chk(mix_cnt == 0 && any_seg == 0, "R2 bank overlap", mix_cnt, 0);
      chk(com_cnt == 2 * ON, "R3 common duty", com_cnt, 2 * ON);
    end
    cap = 1000; full_ref = 1000;
    scan(FR);
    chk(s0_cnt == ON && s1_cnt == ON, "R3 bank window", s0_cnt + s1_cnt, 2 * ON);
    warn_low = 1;
    scan(8 * BH);
    chk(s2_no_s0 > 0, "R4 blink dark", s2_no_s0, 1);
    chk(s2_with_s0 > 0, "R4 blink lit", s2_with_s0, 1);
    chk(or_mask == 5'b11111, "R4 others lit", or_mask, 31);
    warn_low = 0;
    scan(4 * BH);
    chk(s2_no_s0 == 0, "R4 no blink", s2_no_s0, 0);
    warn_empty = 1;
    scan(3 * FR);
    chk(or_mask == 0, "R5 blank", or_mask, 0);
    warn_empty = 0;
    chg_active = 0;
    scan(2 * FR);
    chk(com_cnt == 0 && or_mask == 0, "R6 no charge", com_cnt, 0);
    disp_mode = 2'b10; chg_active = 1;
    scan(2 * FR);
    chk(com_cnt == 0 && or_mask == 0, "R6 mode off", com_cnt, 0);
    disp_mode = 2'b11;
    scan(2 * FR);
    chk(com_cnt == 0, "R6 mode off alt", com_cnt, 0);
    chg_active = 0;
    disp_mode = 2'b00;
    scan(20);
    chk(com_cnt > 0 && or_mask == 5'b11111, "R7 show on", com_cnt, 1);
    scan(25);
    scan(10);
    chk(com_cnt == 0 && or_mask == 0, "R7 show ended", com_cnt, 0);
    disp_mode = 2'b01;
    @(negedge clk);
    disp_mode = 2'b00;
    scan(25);
    disp_mode = 2'b01;
    @(negedge clk);
    disp_mode = 2'b00;
    scan(19);
    scan(10);
    chk(com_cnt > 0, "R7 restart", com_cnt, 1);
    scan(20);
    scan(10);
    chk(com_cnt == 0, "R7 restart end", com_cnt, 0);
    disp_mode = 2'b00;
    @(negedge clk);
    disp_mode = 2'b01;
    @(negedge clk);
    disp_mode = 2'b00;
    @(negedge clk);
    disp_mode = 2'b10;
    scan(FR);
    chk(com_cnt == 0, "R6 off cancels show", com_cnt, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule